// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into host-owned buffers. Its bookkeeping is a ring of descriptors held in an external descriptor memory. Each descriptor carries an ownership bit, a wrap bit, two error bits, a length and a buffer pointer. When a frame starts, the engine reads the descriptor at its current ring index. If the host has marked that descriptor empty, the engine streams the frame's bytes into the buffer it points to. At the end of the frame it writes the descriptor back with the empty bit clear, which hands it to the host. The host reads the length and the error bits, then sets the empty bit again to return the descriptor.

If the engine finds the current descriptor still owned by the host, it drops the frame, raises a busy event and halts. It leaves the halt only after the host has cleared the event and then issued a clear-halt command.

A graceful stop request lets any frame in progress finish. The engine then reports stop-complete and drops new frames until the request is withdrawn. Every dropped frame adds one to a drop counter.

Top module: `rxbd_ring_engine`

## Requirements
- R1: After reset, `evt_busy_o`, `halted_o` and `evt_grsc_o` are 0, `drop_cnt_o` is 0, no memory write is issued, and `desc_addr_o` is 0.
- R2: The bytes of an accepted frame are written in arrival order to consecutive buffer addresses, starting at the descriptor's buffer pointer (bits 15:0).
- R3: On the last byte the descriptor is rewritten. Bit 31 (empty) is cleared, bit 30 (wrap) and bits 15:0 (pointer) are kept, and bits 27:16 hold the byte count, which includes the 4-byte FCS carried in the stream.
- R4: A frame whose `rx_err_i` is high on any byte is completed with bit 28 (frame error) set. Frames without error have bit 28 clear.
- R5: A frame longer than `max_len_i` has only its first `max_len_i` bytes written. Its length field is `max_len_i` and bit 29 (oversize) is set. A frame of exactly `max_len_i` bytes is stored whole, with bit 29 clear.
- R6: After completing a descriptor whose wrap bit is set, the next frame uses index `base_ptr_i`. Otherwise it uses the next index.
- R7: A frame that starts while the current descriptor has bit 31 clear is dropped whole. It sets `evt_busy_o` and `halted_o` and leaves the descriptor and its buffer untouched.
- R8: While halted, frames are dropped. `clr_halt_i` is ignored while `evt_busy_o` is set. `busy_clr_i` clears `evt_busy_o` without releasing the halt. A `clr_halt_i` pulse after that resumes reception at the same descriptor.
- R9: With `grs_i` high, a frame already in progress completes normally, and `evt_grsc_o` rises the cycle after reception goes idle. Frames that start while `grs_i` is high are dropped. Lowering `grs_i` clears `evt_grsc_o` and resumes reception.
- R10: `drop_cnt_o` increases by exactly one for each dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte valid on the receive stream |
| rx_data_i | input | 8 | Received byte |
| rx_last_i | input | 1 | Marks the final byte of a frame |
| rx_err_i | input | 1 | Error indication for the current byte |
| base_ptr_i | input | DESC_AW | Ring index used after a wrap descriptor |
| max_len_i | input | 12 | Largest number of bytes stored per buffer |
| busy_clr_i | input | 1 | Clears the busy event |
| clr_halt_i | input | 1 | Clear-halt command |
| grs_i | input | 1 | Graceful receive stop request |
| evt_busy_o | output | 1 | Busy event: no empty descriptor was available |
| evt_grsc_o | output | 1 | Graceful stop complete |
| halted_o | output | 1 | Reception halted |
| drop_cnt_o | output | DROP_W | Dropped frame count, wraps |
| desc_addr_o | output | DESC_AW | Descriptor memory index, current ring entry |
| desc_rdata_i | input | 32 | Descriptor read data, combinational read |
| desc_we_o | output | 1 | Descriptor write strobe |
| desc_wdata_o | output | 32 | Descriptor write data |
| buf_we_o | output | 1 | Buffer byte write strobe |
| buf_addr_o | output | 16 | Buffer byte address |
| buf_data_o | output | 8 | Buffer byte data |

## Verification
The checker assumes several things about the environment. Descriptor memory answers in the same cycle it is addressed. `base_ptr_i` and `max_len_i` are held steady. The host does not rewrite the descriptor the engine is filling. Given these, it can demand that no buffer write occurs while halted or stopped, and that a written length never exceeds `max_len_i`. The bench's memory model reads combinationally and commits writes on the clock edge. The bench changes configuration and host-side descriptors only on falling edges, and only between frames. Command inputs are single-cycle pulses.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int unsigned LEN_W = 12;
  localparam int unsigned PTR_W = 16;

  typedef struct packed {
    logic             empty;
    logic             wrap;
    logic             oversize;
    logic             frame_err;
    logic [LEN_W-1:0] len;
    logic [PTR_W-1:0] buf_ptr;
  } desc_t;

  localparam int unsigned DESC_W = $bits(desc_t);
endpackage

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl #(
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_set_i,
  input  logic              drop_i,
  input  logic              rcv_active_i,
  input  logic              busy_clr_i,
  input  logic              clr_halt_i,
  input  logic              grs_i,
  output logic              evt_busy_o,
  output logic              halted_o,
  output logic              evt_grsc_o,
  output logic              accept_ok_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic busy_q, halt_q, grsc_q;
  logic [DROP_W-1:0] drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      halt_q <= 1'b0;
      grsc_q <= 1'b0;
      drop_q <= '0;
    end else begin
      if (busy_set_i)      busy_q <= 1'b1;
      else if (busy_clr_i) busy_q <= 1'b0;
      // halt release needs the busy event already cleared
      if (busy_set_i)                 halt_q <= 1'b1;
      else if (clr_halt_i && !busy_q) halt_q <= 1'b0;
      if (!grs_i)             grsc_q <= 1'b0;
      else if (!rcv_active_i) grsc_q <= 1'b1;
      if (drop_i) drop_q <= drop_q + 1'b1;
    end
  end

  assign evt_busy_o  = busy_q;
  assign halted_o    = halt_q;
  assign evt_grsc_o  = grsc_q;
  assign accept_ok_o = !halt_q && !grs_i;
  assign drop_cnt_o  = drop_q;
endmodule

// File: rtl/rxbd_frame.sv
module rxbd_frame
  import rxbd_pkg::*;
#(
  parameter int unsigned DESC_AW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_last_i,
  input  logic               rx_err_i,
  input  logic               accept_ok_i,
  input  desc_t              desc_rd_i,
  input  logic [DESC_AW-1:0] base_i,
  input  logic [LEN_W-1:0]   max_len_i,
  output logic [DESC_AW-1:0] desc_addr_o,
  output logic               desc_we_o,
  output desc_t              desc_wd_o,
  output logic               buf_we_o,
  output logic [PTR_W-1:0]   buf_addr_o,
  output logic [7:0]         buf_data_o,
  output logic               busy_set_o,
  output logic               drop_o,
  output logic               rcv_active_o
);
  logic               in_frame_q, keep_q, wrap_q, ovr_q, err_q;
  logic [LEN_W-1:0]   cnt_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [DESC_AW-1:0] cur_q;

  logic start, take, active, fits;
  logic wrap_now, ovr_now, err_now;
  logic [LEN_W-1:0] cnt_now, cnt_next;
  logic [PTR_W-1:0] ptr_now;

  logic unused_fields;
  assign unused_fields = ^{desc_rd_i.len, desc_rd_i.oversize, desc_rd_i.frame_err};

  always_comb begin
    start    = rx_valid_i && !in_frame_q;
    take     = start && accept_ok_i && desc_rd_i.empty;
    active   = take || (in_frame_q && keep_q);
    cnt_now  = start ? '0 : cnt_q;
    ptr_now  = start ? desc_rd_i.buf_ptr : ptr_q;
    wrap_now = start ? desc_rd_i.wrap : wrap_q;
    ovr_now  = start ? 1'b0 : ovr_q;
    err_now  = start ? 1'b0 : err_q;
    fits     = cnt_now < max_len_i;
    cnt_next = fits ? cnt_now + 1'b1 : cnt_now;

    desc_wd_o           = '0;
    desc_wd_o.empty     = 1'b0;
    desc_wd_o.wrap      = wrap_now;
    desc_wd_o.oversize  = ovr_now || !fits;
    desc_wd_o.frame_err = err_now || rx_err_i;
    desc_wd_o.len       = cnt_next;
    desc_wd_o.buf_ptr   = ptr_now;
  end

  assign busy_set_o   = start && accept_ok_i && !desc_rd_i.empty;
  assign drop_o       = start && !take;
  assign buf_we_o     = rx_valid_i && active && fits;
  assign buf_addr_o   = ptr_now + PTR_W'(cnt_now);
  assign buf_data_o   = rx_data_i;
  assign desc_we_o    = rx_valid_i && active && rx_last_i;
  assign desc_addr_o  = cur_q;
  assign rcv_active_o = in_frame_q && keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
      wrap_q     <= 1'b0;
      ovr_q      <= 1'b0;
      err_q      <= 1'b0;
      cnt_q      <= '0;
      ptr_q      <= '0;
      cur_q      <= '0;
    end else if (rx_valid_i) begin
      in_frame_q <= !rx_last_i;
      keep_q     <= active;
      cnt_q      <= cnt_next;
      ptr_q      <= ptr_now;
      wrap_q     <= wrap_now;
      ovr_q      <= ovr_now || !fits;
      err_q      <= err_now || rx_err_i;
      if (desc_we_o) cur_q <= wrap_now ? base_i : cur_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
  import rxbd_pkg::*;
#(
  parameter int unsigned DESC_AW = 4,
  parameter int unsigned DROP_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_data_i,
  input  logic                rx_last_i,
  input  logic                rx_err_i,
  input  logic [DESC_AW-1:0]  base_ptr_i,
  input  logic [LEN_W-1:0]    max_len_i,
  input  logic                busy_clr_i,
  input  logic                clr_halt_i,
  input  logic                grs_i,
  output logic                evt_busy_o,
  output logic                evt_grsc_o,
  output logic                halted_o,
  output logic [DROP_W-1:0]   drop_cnt_o,
  output logic [DESC_AW-1:0]  desc_addr_o,
  input  logic [DESC_W-1:0]   desc_rdata_i,
  output logic                desc_we_o,
  output logic [DESC_W-1:0]   desc_wdata_o,
  output logic                buf_we_o,
  output logic [PTR_W-1:0]    buf_addr_o,
  output logic [7:0]          buf_data_o
);
  logic  busy_set, drop, rcv_active, accept_ok;
  desc_t desc_rd, desc_wd;

  assign desc_rd      = desc_t'(desc_rdata_i);
  assign desc_wdata_o = desc_wd;

  rxbd_frame #(.DESC_AW(DESC_AW)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .rx_last_i    (rx_last_i),
    .rx_err_i     (rx_err_i),
    .accept_ok_i  (accept_ok),
    .desc_rd_i    (desc_rd),
    .base_i       (base_ptr_i),
    .max_len_i    (max_len_i),
    .desc_addr_o  (desc_addr_o),
    .desc_we_o    (desc_we_o),
    .desc_wd_o    (desc_wd),
    .buf_we_o     (buf_we_o),
    .buf_addr_o   (buf_addr_o),
    .buf_data_o   (buf_data_o),
    .busy_set_o   (busy_set),
    .drop_o       (drop),
    .rcv_active_o (rcv_active)
  );

  rxbd_ctrl #(.DROP_W(DROP_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_set_i   (busy_set),
    .drop_i       (drop),
    .rcv_active_i (rcv_active),
    .busy_clr_i   (busy_clr_i),
    .clr_halt_i   (clr_halt_i),
    .grs_i        (grs_i),
    .evt_busy_o   (evt_busy_o),
    .halted_o     (halted_o),
    .evt_grsc_o   (evt_grsc_o),
    .accept_ok_o  (accept_ok),
    .drop_cnt_o   (drop_cnt_o)
  );
endmodule

// File: rtl/rxbd_ring_engine_chk.sv
module rxbd_ring_engine_chk
  import rxbd_pkg::*;
#(
  parameter int unsigned DESC_AW = 4,
  parameter int unsigned DROP_W  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_halt_i,
  input logic [LEN_W-1:0]    max_len_i,
  input logic                evt_busy_o,
  input logic                evt_grsc_o,
  input logic                halted_o,
  input logic [DROP_W-1:0]   drop_cnt_o,
  input logic                desc_we_o,
  input logic [DESC_W-1:0]   desc_wdata_o,
  input logic                buf_we_o
);
  desc_t wd;
  assign wd = desc_t'(desc_wdata_o);

  // R7
  busy_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_busy_o) |-> halted_o);

  // R8
  halt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> ($past(clr_halt_i) && !$past(evt_busy_o)));

  // R8
  no_write_halted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!buf_we_o && !desc_we_o));

  // R9
  no_write_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_grsc_o |-> (!buf_we_o && !desc_we_o));

  // R5
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> (wd.len <= max_len_i));

  // R10
  drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drop_cnt_o) |-> (drop_cnt_o == DROP_W'($past(drop_cnt_o) + 1'b1)));
endmodule

bind rxbd_ring_engine rxbd_ring_engine_chk #(.DESC_AW(DESC_AW), .DROP_W(DROP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_halt_i   (clr_halt_i),
  .max_len_i    (max_len_i),
  .evt_busy_o   (evt_busy_o),
  .evt_grsc_o   (evt_grsc_o),
  .halted_o     (halted_o),
  .drop_cnt_o   (drop_cnt_o),
  .desc_we_o    (desc_we_o),
  .desc_wdata_o (desc_wdata_o),
  .buf_we_o     (buf_we_o)
);

// File: tb/rxbd_ring_engine_test.sv
module rxbd_ring_engine_test;
  localparam int NV = 8;
  localparam int VLEN [NV] = '{1, 7, 20, 25, 3, 12, 40, 2};
  localparam bit VERR [NV] = '{0, 0, 0, 0, 1, 0, 1, 0};
  localparam int MAXL = 20;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_last = 0, rx_err = 0;
  logic [7:0] rx_data = '0;
  logic [3:0] base_ptr = '0;
  logic [11:0] max_len = 12'(MAXL);
  logic busy_clr = 0, clr_halt = 0, grs = 0;
  logic evt_busy, evt_grsc, halted, desc_we, buf_we;
  logic [7:0] drop_cnt, buf_data;
  logic [3:0] desc_addr;
  logic [31:0] desc_rdata, desc_wdata;
  logic [15:0] buf_addr;

  logic [31:0] dmem [16];
  logic [7:0]  bmem [1024];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign desc_rdata = dmem[desc_addr];
  always @(posedge clk) begin
    if (desc_we) dmem[desc_addr] <= desc_wdata;
    if (buf_we)  bmem[buf_addr[9:0]] <= buf_data;
  end

  rxbd_ring_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_err_i(rx_err), .base_ptr_i(base_ptr), .max_len_i(max_len),
    .busy_clr_i(busy_clr), .clr_halt_i(clr_halt), .grs_i(grs),
    .evt_busy_o(evt_busy), .evt_grsc_o(evt_grsc), .halted_o(halted), .drop_cnt_o(drop_cnt),
    .desc_addr_o(desc_addr), .desc_rdata_i(desc_rdata), .desc_we_o(desc_we),
    .desc_wdata_o(desc_wdata), .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_data_o(buf_data)
  );

  function automatic logic [7:0] pat(int tag, int b);
    return 8'(tag * 37 + b * 11 + 5);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic give_back(int idx);
    dmem[idx] = {1'b1, idx == 3, 2'b00, 12'd0, 16'(idx * 64)};
    for (int i = 0; i < 64; i++) bmem[idx * 64 + i] = 8'hEE;
  endtask

  task automatic send_frame(int len, bit err, int tag);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = pat(tag, b);
      rx_last = (b == len - 1); rx_err = err && (b == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  function automatic bit buf_ok(int idx, int w, int tag);
    for (int b = 0; b < w; b++)
      if (bmem[idx * 64 + b] !== pat(tag, b)) return 0;
    if (w < 64 && bmem[idx * 64 + w] !== 8'hEE) return 0;
    return 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx, w;
    logic [31:0] saved;
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    for (int i = 0; i < 4; i++) give_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 flags", {evt_busy, halted, evt_grsc, desc_we, buf_we}, 0);
    chk("R1 drop/addr", {drop_cnt, desc_addr}, 0);

    // table walk: R2 R3 R4 R5 R6
    idx = 0;
    for (int f = 0; f < NV; f++) begin
      w = (VLEN[f] > MAXL) ? MAXL : VLEN[f];
      send_frame(VLEN[f], VERR[f], f);
      chk("R3 R4 R5 descriptor", dmem[idx],
          {1'b0, idx == 3, VLEN[f] > MAXL, VERR[f], 12'(w), 16'(idx * 64)});
      chk("R2 R5 buffer", 32'(buf_ok(idx, w, f)), 1);
      idx = (idx == 3) ? 0 : idx + 1;
      chk("R6 next index", 32'(desc_addr), 32'(idx));
      give_back((idx + 3) % 4);
    end

    // R7: current descriptor still host-owned
    saved = {1'b0, 1'b0, 2'b00, 12'd0, 16'd0};
    dmem[0] = saved;
    send_frame(4, 0, 50);
    chk("R7 busy", 32'(evt_busy), 1);
    chk("R7 halted", 32'(halted), 1);
    chk("R10 drop count", 32'(drop_cnt), 1);
    chk("R7 desc untouched", dmem[0], saved);
    chk("R7 buffer untouched", 32'(bmem[0]), 32'hEE);

    // R8
    send_frame(3, 0, 51);
    chk("R8 drop while halted", 32'(drop_cnt), 2);
    @(negedge clk); clr_halt = 1; @(negedge clk); clr_halt = 0;
    chk("R8 clr_halt ignored while busy", 32'(halted), 1);
    @(negedge clk); busy_clr = 1; @(negedge clk); busy_clr = 0;
    chk("R8 busy cleared, still halted", {evt_busy, halted}, 32'b01);
    @(negedge clk); clr_halt = 1; @(negedge clk); clr_halt = 0;
    chk("R8 resumed", 32'(halted), 0);
    give_back(0);
    send_frame(5, 0, 52);
    chk("R8 frame after resume", dmem[0], {4'b0000, 12'd5, 16'd0});
    chk("R8 no extra drop", 32'(drop_cnt), 2);

    // R9: graceful stop raised mid-frame
    for (int b = 0; b < 10; b++) begin
      @(negedge clk);
      if (b == 6) chk("R9 no stop-complete mid-frame", 32'(evt_grsc), 0);
      if (b == 3) grs = 1;
      rx_valid = 1; rx_data = pat(53, b); rx_last = (b == 9); rx_err = 0;
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
    chk("R9 frame completed", dmem[1], {4'b0000, 12'd10, 16'd64});
    @(negedge clk);
    chk("R9 stop complete", 32'(evt_grsc), 1);
    send_frame(3, 0, 54);
    chk("R9 R10 dropped while stopped", 32'(drop_cnt), 3);
    chk("R9 desc kept", dmem[2], {1'b1, 3'b000, 12'd0, 16'd128});
    grs = 0;
    @(negedge clk);
    chk("R9 stop released", {evt_grsc, evt_busy}, 0);
    send_frame(2, 0, 55);
    chk("R9 resumed frame", dmem[2], {4'b0000, 12'd2, 16'd128});
    chk("R9 buffer", 32'(buf_ok(2, 2, 55)), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule